// File: doc/BRIEF.md
# Framed Receiver Strobe Pulse Generator

This block runs on the bit-rate clock of a serial receiver, where each clock period is one encoded bit time. It steps a position counter through every received symbol frame and issues a single strobe pulse per frame at a fixed offset from the frame's first bit. The frame length and the pulse width follow a payload-mode input that selects an 8-, 9- or 10-bit payload.

A command/data flag, sampled at the first bit of each frame, picks which of two strobe outputs carries that frame's pulse. Logic downstream of the receiver uses the two outputs as qualifiers for the command and data words.

A resync pulse realigns the frame boundary to the incoming stream. If a strobe is high when the boundary moves, the pulse is stretched to the new frame's nominal fall point rather than being cut. The stretch is bounded, so the pulse can never stay high for more than a fixed number of bit times beyond its nominal width.

Top module: `rx_strobe_gen`

## Requirements
- R1: The frame length is 10 bit times for mode code 0 (8-bit payload), 11 for code 1 (9-bit), 12 for code 2 (10-bit), and 10 for the reserved code 3. Consecutive frames start exactly one frame length apart.
- R2: The strobe rises two bit times after frame state 0, so it is first high in the cycle where the frame position is 2.
- R3: In modes 0 and 3 the nominal strobe width is 4 bit times. In modes 1 and 2 it is 5 bit times.
- R4: `cmdNotData` is sampled in frame state 0. A value of 1 routes that frame's pulse to `cmdStrobe`, and 0 routes it to `dataStrobe`. The two outputs are never high together, and a pulse never moves from one output to the other.
- R5: When `resync` is high in a cycle, the frame position is 0 in the following cycle, and a new frame begins there.
- R6: If a strobe is high in the cycle where `resync` is applied, it stays high on the same output until the new frame's nominal fall point. The command/data flag is not resampled while that pulse is high.
- R7: The total high time of one pulse never exceeds the nominal width plus 5 bit times. When that limit is reached, the strobe falls and stays low for the rest of that frame's strobe window.
- R8: A change of `payloadMode` after frame state 0 does not alter the current frame. It takes effect at the next frame start.
- R9: While `rst` is high, both strobes are low, and the frame that follows reset starts in state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| payloadMode | input | 2 | Payload mode: 0 = 8-bit, 1 = 9-bit, 2 = 10-bit, 3 = reserved (acts as 8-bit) |
| cmdNotData | input | 1 | 1 = command symbol, 0 = data symbol; sampled at frame state 0 |
| resync | input | 1 | Realign the frame boundary; position is 0 on the next clock |
| cmdStrobe | output | 1 | Strobe pulse for command frames |
| dataStrobe | output | 1 | Strobe pulse for data frames |

## Verification
The bench builds the block with its default parameters: a rise offset of 2 and a stretch allowance of 5. With these values, a resync placed late in the strobe window pushes the stretched pulse past the cap in both the 4-bit and the 5-bit width classes, so the capped fall and the blocked remainder of the window can be observed at the ports. Resync is applied at every frame position in three modes, which covers realignment before the window, inside the window and after it.

// File: rtl/rx_strobe_pkg.sv
package rx_strobe_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    MODE_P8  = 2'd0,
    MODE_P9  = 2'd1,
    MODE_P10 = 2'd2,
    MODE_RSV = 2'd3
  } payloadModeT;

  localparam int LEN_P8  = 10;
  localparam int LEN_P9  = 11;
  localparam int LEN_P10 = 12;
  localparam int WID_NARROW = 4;
  localparam int WID_WIDE   = 5;

  function automatic int frameBits(payloadModeT m);
    case (m)
      MODE_P9:  return LEN_P9;
      MODE_P10: return LEN_P10;
      default:  return LEN_P8;
    endcase
  endfunction

  function automatic int pulseBits(payloadModeT m);
    case (m)
      MODE_P9, MODE_P10: return WID_WIDE;
      default:           return WID_NARROW;
    endcase
  endfunction

  // Strobes handed from the frame control to the strobe datapath
  typedef struct packed {
    logic             head;     // current frame position is 0
    logic             winNext;  // next position lies inside the nominal window
    logic             preNext;  // next position lies before the rise offset
    logic [CNT_W-1:0] capLen;   // maximum high time of one pulse
  } frameCtrlT;

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_strobe_pkg::*;
#(
  parameter int RISE_OFS    = 2,
  parameter int STRETCH_MAX = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] payloadMode,
  input  logic      resync,
  output frameCtrlT ctrl
);

  localparam logic [CNT_W-1:0] RISE = CNT_W'(RISE_OFS);
  localparam logic [CNT_W-1:0] SLACK = CNT_W'(STRETCH_MAX);

  logic [CNT_W-1:0] pos, nextPos, lenReg, widReg;

  always_comb begin
    if (resync)                          nextPos = '0;
    else if (pos == lenReg - CNT_W'(1))  nextPos = '0;
    else                                 nextPos = pos + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      lenReg <= CNT_W'(LEN_P8);
      widReg <= CNT_W'(WID_NARROW);
    end else begin
      pos <= nextPos;
      if (pos == '0) begin
        lenReg <= CNT_W'(frameBits(payloadModeT'(payloadMode)));
        widReg <= CNT_W'(pulseBits(payloadModeT'(payloadMode)));
      end
    end
  end

  always_comb begin
    ctrl.head    = (pos == '0);
    ctrl.winNext = (nextPos >= RISE) && (nextPos < RISE + widReg);
    ctrl.preNext = (nextPos < RISE);
    ctrl.capLen  = widReg + SLACK;
  end

  // R1: position stays inside the latched frame and wraps at its end
  assert_pos_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
    pos < lenReg);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (pos == lenReg - CNT_W'(1) && !resync) |=> (pos == '0));
  // R5: resync realigns the frame on the next clock
  assert_resync_realign_R5: assert property (@(posedge clk) disable iff (rst)
    resync |=> (pos == '0));
  // R8: frame length changes only after a state-0 cycle
  assert_len_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pos) != '0) |-> $stable(lenReg));

endmodule

// File: rtl/rx_strobe_path.sv
module rx_strobe_path
  import rx_strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdNotData,
  input  frameCtrlT ctrl,
  output logic      cmdStrobe,
  output logic      dataStrobe
);

  logic strbQ, kindQ, cutQ;
  logic [CNT_W-1:0] hiRun;
  logic want, limitHit, cutD, strbD;
  logic [CNT_W-1:0] hiRunD;

  always_comb begin
    want     = ctrl.winNext || (strbQ && ctrl.preNext);
    limitHit = strbQ && (hiRun >= ctrl.capLen);
    cutD     = want && (cutQ || limitHit);
    strbD    = want && !cutD;
    if (!strbD)     hiRunD = '0;
    else if (strbQ) hiRunD = hiRun + CNT_W'(1);
    else            hiRunD = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strbQ <= 1'b0;
      cutQ  <= 1'b0;
      hiRun <= '0;
      kindQ <= 1'b0;
    end else begin
      strbQ <= strbD;
      cutQ  <= cutD;
      hiRun <= hiRunD;
      if (ctrl.head && !strbQ) kindQ <= cmdNotData;
    end
  end

  assign cmdStrobe  = strbQ & kindQ;
  assign dataStrobe = strbQ & ~kindQ;

  // R4: a pulse never hops between the outputs
  assert_cmd_no_hop_R4: assert property (@(posedge clk) disable iff (rst)
    cmdStrobe |=> !dataStrobe);
  assert_data_no_hop_R4: assert property (@(posedge clk) disable iff (rst)
    dataStrobe |=> !cmdStrobe);
  // R7: high time bounded, and a cut pulse stays low
  assert_run_capped_R7: assert property (@(posedge clk) disable iff (rst)
    strbQ |-> (hiRun <= ctrl.capLen));
  assert_cut_low_R7: assert property (@(posedge clk) disable iff (rst)
    cutQ |-> !strbQ);

endmodule

// File: rtl/rx_strobe_gen.sv
module rx_strobe_gen
  import rx_strobe_pkg::*;
#(
  parameter int RISE_OFS    = 2,
  parameter int STRETCH_MAX = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] payloadMode,
  input  logic       cmdNotData,
  input  logic       resync,
  output logic       cmdStrobe,
  output logic       dataStrobe
);

  frameCtrlT ctrl;

  rx_frame_ctrl #(
    .RISE_OFS   (RISE_OFS),
    .STRETCH_MAX(STRETCH_MAX)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .payloadMode(payloadMode),
    .resync     (resync),
    .ctrl       (ctrl)
  );

  rx_strobe_path u_path (
    .clk       (clk),
    .rst       (rst),
    .cmdNotData(cmdNotData),
    .ctrl      (ctrl),
    .cmdStrobe (cmdStrobe),
    .dataStrobe(dataStrobe)
  );

  // R9: reset drives both strobes low
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!cmdStrobe && !dataStrobe));

endmodule

// File: tb/rx_strobe_gen_test.sv
module rx_strobe_gen_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] payloadMode = 2'd0;
  logic cmdNotData = 1'b0;
  logic resync = 1'b0;
  logic cmdStrobe, dataStrobe;

  rx_strobe_gen uut (
    .clk        (clk),
    .rst        (rst),
    .payloadMode(payloadMode),
    .cmdNotData (cmdNotData),
    .resync     (resync),
    .cmdStrobe  (cmdStrobe),
    .dataStrobe (dataStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit    kind;
    int    start;
    int    width;
    string tag;
  } pulseT;

  pulseT expQ[$];
  int cyc = 0;
  int vectors = 0;
  int fails = 0;
  int fStart = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected frame geometry, taken from R1 and R3
  function automatic int expLen(int m);
    case (m)
      1: return 11;
      2: return 12;
      default: return 10;
    endcase
  endfunction

  function automatic int expWid(int m);
    return (m == 1 || m == 2) ? 5 : 4;
  endfunction

  task automatic gotoCycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pushExp(input bit k, input int s, input int w, input string t);
    pulseT p;
    p.kind = k; p.start = s; p.width = w; p.tag = t;
    expQ.push_back(p);
  endtask

  // Plain frame; mode input changed mid-frame to midM (R8)
  task automatic runFrame(input int m, input bit k, input int midM);
    gotoCycle(fStart);
    payloadMode = 2'(m);
    cmdNotData  = k;
    pushExp(k, fStart + 2, expWid(m), (m == midM) ? "R1 R2 R3 R4" : "R8 R1 R3");
    gotoCycle(fStart + 5);
    payloadMode = 2'(midM);
    fStart = fStart + expLen(m);
  endtask

  // Frame with resync at position p (R5, R6, R7)
  task automatic runResync(input int m, input bit k, input int p);
    int w, g, tot;
    w = expWid(m);
    g = fStart + p + 1;
    gotoCycle(fStart);
    payloadMode = 2'(m);
    cmdNotData  = k;
    if (p >= 2 && p <= 1 + w) begin
      tot = p + 1 + w;
      if (tot > w + 5) pushExp(k, fStart + 2, w + 5, "R7 cap");
      else             pushExp(k, fStart + 2, tot, "R6 stretch");
    end else if (p > 1 + w) begin
      pushExp(k, fStart + 2, w, "R3 pre-resync");
      pushExp(!k, g + 2, w, "R5 realign");
    end else begin
      pushExp(!k, g + 2, w, "R5 realign");
    end
    gotoCycle(fStart + p);
    resync = 1'b1;
    gotoCycle(g);
    resync = 1'b0;
    cmdNotData = !k;
    fStart = g + expLen(m);
  endtask

  // Monitor: measures pulses at the ports and compares with the scoreboard
  bit inP = 1'b0;
  bit pKind;
  int pStart, pWidth;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cmdStrobe && dataStrobe) begin
        fails++;
        $display("FAIL R4 both strobes high at cycle %0d: actual 2 high, expected at most 1", cyc);
      end
      if ((cmdStrobe || dataStrobe) && !inP) begin
        inP = 1'b1; pStart = cyc; pWidth = 1; pKind = cmdStrobe;
      end else if ((cmdStrobe || dataStrobe) && inP) begin
        pWidth++;
        if (cmdStrobe != pKind) begin
          fails++;
          $display("FAIL R4 output hop at cycle %0d: actual kind %0d, expected %0d", cyc, cmdStrobe, pKind);
        end
      end else if (inP) begin
        pulseT e;
        inP = 1'b0;
        vectors++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected pulse: actual start %0d width %0d, expected none", pStart, pWidth);
        end else begin
          e = expQ.pop_front();
          if (e.kind != pKind || e.start != pStart || e.width != pWidth) begin
            fails++;
            $display("FAIL %s: actual kind %0d start %0d width %0d, expected kind %0d start %0d width %0d",
                     e.tag, pKind, pStart, pWidth, e.kind, e.start, e.width);
          end
        end
      end
    end
  end

  // Driver
  initial begin
    // R9: strobes low during reset
    gotoCycle(1);
    for (int i = 0; i < 3; i++) begin
      vectors++;
      if (cmdStrobe || dataStrobe) begin
        fails++;
        $display("FAIL R9 strobe during reset: actual %0d%0d, expected 00", cmdStrobe, dataStrobe);
      end
      @(negedge clk);
    end
    gotoCycle(4);
    rst = 1'b0;
    fStart = 4;

    for (int m = 0; m < 4; m++) begin
      runFrame(m, 1'b1, m);
      runFrame(m, 1'b0, m);
    end
    runFrame(0, 1'b1, 2);
    runFrame(2, 1'b0, 0);
    runFrame(1, 1'b1, 3);
    runFrame(3, 1'b0, 1);

    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < expLen(m); p++) begin
        runResync(m, 1'(p % 2), p);
        runFrame(m, 1'(p % 2), m);
      end
    end

    gotoCycle(fStart + 1);
    done = 1'b1;
    vectors++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1 missing pulses: actual %0d pending, expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: actual cycle %0d, expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule